// File: doc/BRIEF.md
# Multiply-Accumulate Execution Unit with Saturation

This unit is the multiply/accumulate execution slice of a 64-bit integer core. Each valid request carries two 64-bit register operands, a 6-bit function code and a 5-bit shift-amount field. Together the two fields select one operation:

- plain multiply
- multiply-accumulate, plain or saturating
- multiply-negate
- multiply-subtract
- a "double" accumulate that works on the whole LO register

The unit holds the HI and LO registers. In the ordinary forms they act as one 64-bit accumulator, with the upper half in HI bits 31:0 and the lower half in LO bits 31:0. Ordinary forms also return a sign-extended 32-bit half of the new accumulator for the destination register. The double forms write LO only and return nothing.

Every operation completes in one cycle. Inputs are sampled at the rising edge where `valid_i` is high. HI, LO, the destination write strobe and its data all show the result directly after that edge. Pipeline hazards, division and exceptions are handled elsewhere.

Top module: `mulacc_unit`

## Requirements
- R1: While `rst_ni` is low, `hi_o` and `lo_o` are zero and `rd_we_o` is low.
- R2: Ordinary (non-double) forms take the accumulator as {HI[31:0], LO[31:0]}. They write the new accumulator back the same way and leave HI[63:32] and LO[63:32] unchanged.
- R3: The product uses only bits 31:0 of `rs_i` and `rt_i`. It is a full 64-bit product, signed or unsigned. In function code 101000 or 101001, `sa_i[0]`=1 selects unsigned. In function codes 011000 and 011001, function bit 0 = 1 selects unsigned.
- R4: With function code 101000, sa values 00000, 00001, 01000 and 01001 set the accumulator to accumulator + product. `sa_i[3]`=1 selects the high half for the destination register.
- R5: After an ordinary form, `rd_we_o` is high for exactly one cycle. `rd_data_o` is the low half (sa[3]=0) or the high half (sa[3]=1) of the new accumulator, sign-extended to 64 bits.
- R6: Signed saturating accumulate clamps the sum to the range -2^31..2^31-1. It uses function code 101000 with sa 10000 or 11000, or the double form with sa 10000.
- R7: Unsigned saturating accumulate sets the result to all ones when the sum exceeds 0x7FFFFFFF. It uses function code 101000 with sa 10001 or 11001, or the double form with sa 10001.
- R8: Function code 101001 with sa 00000, 00001, 10000 or 10001 adds the product to all 64 bits of LO, treating LO as signed or unsigned to match the product. HI does not change and `rd_we_o` stays low.
- R9: With function code 101000, sa values 00100 (signed, low), 00101 (unsigned, low), 01100 (signed, high) and 01101 (unsigned, high) set the accumulator to the product alone.
- R10: Function code 011000 (signed) or 011001 (unsigned) with sa 00011 (low) or 01011 (high) sets the accumulator to 0 minus the product.
- R11: Function code 011000 (signed) or 011001 (unsigned) with sa 00111 (low) or 01111 (high) sets the accumulator to accumulator minus the product.
- R12: Any other function/sa combination, or a cycle with `valid_i` low, leaves HI and LO unchanged and keeps `rd_we_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Request strobe |
| funct_i | input | 6 | Function code |
| sa_i | input | 5 | Variant selector field |
| rs_i | input | 64 | First operand |
| rt_i | input | 64 | Second operand |
| hi_o | output | 64 | HI register |
| lo_o | output | 64 | LO register |
| rd_we_o | output | 1 | Destination register write strobe |
| rd_data_o | output | 64 | Destination register value |

## Verification
The assertions check several properties on every cycle:
- Idle and undefined requests leave HI and LO untouched.
- Double forms never change HI and never raise the write strobe.
- Ordinary forms keep the upper words of HI and LO.
- The destination value always equals one sign-extended accumulator half.
- After any saturating form the accumulator lies inside its clamp range.

Only the bench scenarios can show the arithmetic itself. These include signed and unsigned products of operands with nonzero upper bits, a clamp reached from both sides, the unsigned jump to all ones, and negate and subtract reading the right base. They also include a double form followed by an ordinary form that must reuse only LO's lower word.

// File: rtl/mulacc_pkg.sv
package mulacc_pkg;
  localparam int FUNCT_W = 6;
  localparam int SA_W    = 5;

  localparam logic [FUNCT_W-1:0] FN_ACC   = 6'b101000;
  localparam logic [FUNCT_W-1:0] FN_DBL   = 6'b101001;
  localparam logic [FUNCT_W-1:0] FN_NEG_S = 6'b011000;
  localparam logic [FUNCT_W-1:0] FN_NEG_U = 6'b011001;

  typedef struct packed {
    logic legal;
    logic dbl;       // accumulate into full LO only
    logic uns;
    logic sat;
    logic high;      // move high half to rd
    logic from_zero; // base is zero instead of accumulator
    logic subtract;  // base minus product
  } mac_op_t;
endpackage

// File: rtl/mulacc_decode.sv
module mulacc_decode
  import mulacc_pkg::*;
(
  input  logic [FUNCT_W-1:0] funct_i,
  input  logic [SA_W-1:0]    sa_i,
  output mac_op_t            op_o
);
  always_comb begin
    op_o = '0;
    unique case (funct_i)
      FN_ACC: begin
        op_o.legal     = !sa_i[1] && !(sa_i[4] && sa_i[2]);
        op_o.uns       = sa_i[0];
        op_o.high      = sa_i[3];
        op_o.sat       = sa_i[4];
        op_o.from_zero = sa_i[2];
      end
      FN_DBL: begin
        op_o.legal = (sa_i[3:1] == 3'b000);
        op_o.dbl   = 1'b1;
        op_o.uns   = sa_i[0];
        op_o.sat   = sa_i[4];
      end
      FN_NEG_S, FN_NEG_U: begin
        op_o.legal     = (sa_i[1:0] == 2'b11) && !sa_i[4];
        op_o.uns       = funct_i[0];
        op_o.high      = sa_i[3];
        op_o.subtract  = 1'b1;
        op_o.from_zero = !sa_i[2];
      end
      default: op_o = '0;
    endcase
  end
endmodule

// File: rtl/mulacc_mult.sv
module mulacc_mult #(
  parameter int HALF_W = 32,
  localparam int PROD_W = 2 * HALF_W
) (
  input  logic [HALF_W-1:0] a_i,
  input  logic [HALF_W-1:0] b_i,
  input  logic              uns_i,
  output logic [PROD_W-1:0] prod_o
);
  logic [PROD_W-1:0] a_x, b_x;
  // one multiplier: the product modulo 2^PROD_W is the same for both signednesses
  always_comb begin
    a_x    = {{HALF_W{!uns_i && a_i[HALF_W-1]}}, a_i};
    b_x    = {{HALF_W{!uns_i && b_i[HALF_W-1]}}, b_i};
    prod_o = a_x * b_x;
  end
endmodule

// File: rtl/mulacc_accum.sv
module mulacc_accum #(
  parameter int DATA_W = 64,
  localparam int HALF_W = DATA_W / 2,
  localparam int EXT_W  = DATA_W + 2
) (
  input  logic [DATA_W-1:0] base_i,
  input  logic [DATA_W-1:0] prod_i,
  input  logic              uns_i,
  input  logic              sat_i,
  input  logic              subtract_i,
  output logic [DATA_W-1:0] result_o
);
  localparam logic signed [EXT_W-1:0] S_MAX = {{(EXT_W-HALF_W+1){1'b0}}, {(HALF_W-1){1'b1}}};
  localparam logic signed [EXT_W-1:0] S_MIN = {{(EXT_W-HALF_W+1){1'b1}}, {(HALF_W-1){1'b0}}};

  logic signed [EXT_W-1:0] a_x, p_x, sum;

  always_comb begin
    a_x = {{2{!uns_i && base_i[DATA_W-1]}}, base_i};
    p_x = {{2{!uns_i && prod_i[DATA_W-1]}}, prod_i};
    sum = subtract_i ? (a_x - p_x) : (a_x + p_x);
    result_o = sum[DATA_W-1:0];
    if (sat_i && !subtract_i) begin
      if (uns_i) begin
        if (sum > S_MAX) result_o = '1;
      end else if (sum > S_MAX) begin
        result_o = S_MAX[DATA_W-1:0];
      end else if (sum < S_MIN) begin
        result_o = S_MIN[DATA_W-1:0];
      end
    end
  end
endmodule

// File: rtl/mulacc_unit.sv
module mulacc_unit
  import mulacc_pkg::*;
#(
  parameter int DATA_W = 64,
  localparam int HALF_W = DATA_W / 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               valid_i,
  input  logic [FUNCT_W-1:0] funct_i,
  input  logic [SA_W-1:0]    sa_i,
  input  logic [DATA_W-1:0]  rs_i,
  input  logic [DATA_W-1:0]  rt_i,
  output logic [DATA_W-1:0]  hi_o,
  output logic [DATA_W-1:0]  lo_o,
  output logic               rd_we_o,
  output logic [DATA_W-1:0]  rd_data_o
);
  mac_op_t           op;
  logic [DATA_W-1:0] hi_q, lo_q, rd_data_q, prod, base, result, rd_val;
  logic              rd_we_q, fire;

  mulacc_decode u_decode (.funct_i(funct_i), .sa_i(sa_i), .op_o(op));

  mulacc_mult #(.HALF_W(HALF_W)) u_mult (
    .a_i(rs_i[HALF_W-1:0]), .b_i(rt_i[HALF_W-1:0]), .uns_i(op.uns), .prod_o(prod)
  );

  always_comb begin
    if (op.dbl)            base = lo_q;
    else if (op.from_zero) base = '0;
    else                   base = {hi_q[HALF_W-1:0], lo_q[HALF_W-1:0]};
  end

  mulacc_accum #(.DATA_W(DATA_W)) u_accum (
    .base_i(base), .prod_i(prod), .uns_i(op.uns), .sat_i(op.sat),
    .subtract_i(op.subtract), .result_o(result)
  );

  assign fire   = valid_i && op.legal;
  assign rd_val = op.high ? {{HALF_W{result[DATA_W-1]}}, result[DATA_W-1:HALF_W]}
                          : {{HALF_W{result[HALF_W-1]}}, result[HALF_W-1:0]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_q      <= '0;
      lo_q      <= '0;
      rd_we_q   <= 1'b0;
      rd_data_q <= '0;
    end else begin
      rd_we_q <= fire && !op.dbl;
      if (fire) begin
        if (op.dbl) begin
          lo_q <= result;
        end else begin
          hi_q      <= {hi_q[DATA_W-1:HALF_W], result[DATA_W-1:HALF_W]};
          lo_q      <= {lo_q[DATA_W-1:HALF_W], result[HALF_W-1:0]};
          rd_data_q <= rd_val;
        end
      end
    end
  end

  assign hi_o      = hi_q;
  assign lo_o      = lo_q;
  assign rd_we_o   = rd_we_q;
  assign rd_data_o = rd_data_q;

  p_reset_clear_r1: assert property (@(posedge clk_i)
    !rst_ni |=> (hi_o == '0 && lo_o == '0 && !rd_we_o));

  p_upper_keep_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire && !op.dbl) |=> ($stable(hi_o[DATA_W-1:HALF_W]) && $stable(lo_o[DATA_W-1:HALF_W])));

  p_rd_half_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_we_o |-> ((rd_data_o[HALF_W-1:0] == hi_o[HALF_W-1:0] ||
                  rd_data_o[HALF_W-1:0] == lo_o[HALF_W-1:0]) &&
                 rd_data_o[DATA_W-1:HALF_W] == {HALF_W{rd_data_o[HALF_W-1]}}));

  p_sclamp_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire && op.sat && !op.uns && !op.dbl) |=> (hi_o[HALF_W-1:0] == {HALF_W{lo_o[HALF_W-1]}}));

  p_uclamp_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire && op.sat && op.uns && !op.dbl) |=>
      ((hi_o[HALF_W-1:0] == '0 && !lo_o[HALF_W-1]) ||
       (hi_o[HALF_W-1:0] == '1 && lo_o[HALF_W-1:0] == '1)));

  p_dbl_hi_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire && op.dbl) |=> ($stable(hi_o) && !rd_we_o));

  p_idle_hold_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fire |=> ($stable(hi_o) && $stable(lo_o) && !rd_we_o));
endmodule

// File: tb/mulacc_unit_tb.sv
`timescale 1ns/1ps
module mulacc_unit_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [5:0]  funct_i = '0;
  logic [4:0]  sa_i = '0;
  logic [63:0] rs_i = '0, rt_i = '0;
  logic [63:0] hi_o, lo_o, rd_data_o;
  logic        rd_we_o;

  int n_cmp = 0, n_bad = 0;

  typedef struct {
    string       tag;
    logic        we;
    logic [63:0] rd, hi, lo;
  } exp_t;
  exp_t exp_q[$];

  logic [63:0] m_hi = '0, m_lo = '0;

  always #4 clk_i = ~clk_i;

  mulacc_unit u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .funct_i(funct_i), .sa_i(sa_i),
    .rs_i(rs_i), .rt_i(rt_i), .hi_o(hi_o), .lo_o(lo_o), .rd_we_o(rd_we_o), .rd_data_o(rd_data_o)
  );

  function automatic logic signed [127:0] x128(input logic [63:0] v, input int w, input bit uns);
    logic signed [127:0] r;
    r = '0;
    for (int i = 0; i < 128; i++) r[i] = (i < w) ? v[i] : (uns ? 1'b0 : v[w-1]);
    return r;
  endfunction

  task automatic issue(input string tag, input logic [5:0] f, input logic [4:0] s,
                       input logic [63:0] a, input logic [63:0] b, input bit v = 1'b1);
    bit legal = 0, dbl = 0, uns = 0, sat = 0, hi_half = 0, zero = 0, sub = 0;
    logic signed [127:0] p, bs, sum;
    logic [63:0] res;
    exp_t e;
    @(negedge clk_i);
    valid_i = v; funct_i = f; sa_i = s; rs_i = a; rt_i = b;
    if (f == 6'b101000) begin
      case (s)
        5'b00000: legal = 1;
        5'b00001: begin legal = 1; uns = 1; end
        5'b01000: begin legal = 1; hi_half = 1; end
        5'b01001: begin legal = 1; uns = 1; hi_half = 1; end
        5'b10000: begin legal = 1; sat = 1; end
        5'b10001: begin legal = 1; sat = 1; uns = 1; end
        5'b11000: begin legal = 1; sat = 1; hi_half = 1; end
        5'b11001: begin legal = 1; sat = 1; uns = 1; hi_half = 1; end
        5'b00100: begin legal = 1; zero = 1; end
        5'b00101: begin legal = 1; zero = 1; uns = 1; end
        5'b01100: begin legal = 1; zero = 1; hi_half = 1; end
        5'b01101: begin legal = 1; zero = 1; uns = 1; hi_half = 1; end
        default: legal = 0;
      endcase
    end else if (f == 6'b101001) begin
      dbl = 1;
      case (s)
        5'b00000: legal = 1;
        5'b00001: begin legal = 1; uns = 1; end
        5'b10000: begin legal = 1; sat = 1; end
        5'b10001: begin legal = 1; sat = 1; uns = 1; end
        default: legal = 0;
      endcase
    end else if (f == 6'b011000 || f == 6'b011001) begin
      uns = f[0];
      sub = 1;
      case (s)
        5'b00011: begin legal = 1; zero = 1; end
        5'b01011: begin legal = 1; zero = 1; hi_half = 1; end
        5'b00111: legal = 1;
        5'b01111: begin legal = 1; hi_half = 1; end
        default: legal = 0;
      endcase
    end
    e.tag = tag;
    e.we  = 1'b0;
    e.rd  = exp_q.size() > 0 ? exp_q[$].rd : (n_cmp == 0 ? 64'h0 : e.rd);
    if (v && legal) begin
      p = x128(a, 32, uns) * x128(b, 32, uns);
      if (dbl)       bs = x128(m_lo, 64, uns);
      else if (zero) bs = '0;
      else           bs = x128({m_hi[31:0], m_lo[31:0]}, 64, uns);
      sum = sub ? bs - p : bs + p;
      res = sum[63:0];
      if (sat) begin
        if (uns) begin
          if (sum > 128'sh7FFFFFFF) res = '1;
        end else if (sum > 128'sh7FFFFFFF) res = 64'h0000_0000_7FFF_FFFF;
        else if (sum < -128'sh80000000) res = 64'hFFFF_FFFF_8000_0000;
      end
      if (dbl) m_lo = res;
      else begin
        m_hi = {m_hi[63:32], res[63:32]};
        m_lo = {m_lo[63:32], res[31:0]};
        e.we = 1'b1;
        e.rd = hi_half ? {{32{res[63]}}, res[63:32]} : {{32{res[31]}}, res[31:0]};
      end
    end
    e.hi = m_hi;
    e.lo = m_lo;
    exp_q.push_back(e);
  endtask

  // monitor: compare one expected item per cycle, just after the edge
  initial begin
    forever begin
      @(posedge clk_i);
      #1;
      if (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        n_cmp++;
        if (rd_we_o !== e.we || hi_o !== e.hi || lo_o !== e.lo || (e.we && rd_data_o !== e.rd)) begin
          n_bad++;
          $display("FAIL %s: act we=%b rd=%h hi=%h lo=%h exp we=%b rd=%h hi=%h lo=%h",
                   e.tag, rd_we_o, rd_data_o, hi_o, lo_o, e.we, e.rd, e.hi, e.lo);
        end
      end
    end
  end

  initial begin
    #(8 * 200000);
    n_bad++;
    $display("FAIL watchdog: act running exp finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    n_cmp++;
    if (hi_o !== '0 || lo_o !== '0 || rd_we_o !== 1'b0) begin
      n_bad++;
      $display("FAIL R1 reset: act hi=%h lo=%h we=%b exp 0 0 0", hi_o, lo_o, rd_we_o);
    end
    rst_ni = 1'b1;

    issue("R4 signed acc low", 6'b101000, 5'b00000, -64'sd3, 64'd7);
    issue("R4 signed acc high", 6'b101000, 5'b01000, 64'h10000, 64'h10000);
    issue("R3 upper operand bits ignored", 6'b101000, 5'b00001, 64'hDEAD_BEEF_0000_0002, 64'h1234_0000_0000_0003);
    issue("R4 unsigned acc high", 6'b101000, 5'b01001, 64'hFFFF_FFFF, 64'hFFFF_FFFF);
    issue("R9 signed mul low", 6'b101000, 5'b00100, -64'sd5, -64'sd6);
    issue("R9 unsigned mul high", 6'b101000, 5'b01101, 64'h8000_0000, 64'd4);
    issue("R9 signed mul high", 6'b101000, 5'b01100, 64'h8000_0000, 64'd4);
    issue("R9 set near max", 6'b101000, 5'b00100, 64'h7FFF_FFF0, 64'd1);
    issue("R6 signed sat upper clamp", 6'b101000, 5'b10000, 64'h100, 64'd1);
    issue("R9 set near min", 6'b101000, 5'b00100, -64'sh7FFF_FFF0, 64'd1);
    issue("R6 signed sat lower clamp high half", 6'b101000, 5'b11000, -64'sh100, 64'd1);
    issue("R6 signed sat in range", 6'b101000, 5'b10000, 64'd5, 64'd5);
    issue("R9 unsigned set small", 6'b101000, 5'b00101, 64'h10, 64'd1);
    issue("R7 unsigned sat no clamp", 6'b101000, 5'b10001, 64'h20, 64'd1);
    issue("R7 unsigned sat to all ones", 6'b101000, 5'b11001, 64'h7FFF_FFF0, 64'd1);
    issue("R10 signed negate low", 6'b011000, 5'b00011, 64'd3, 64'd4);
    issue("R10 unsigned negate high", 6'b011001, 5'b01011, 64'hFFFF_FFFF, 64'd2);
    issue("R11 signed subtract low", 6'b011000, 5'b00111, -64'sd2, 64'd9);
    issue("R11 unsigned subtract high", 6'b011001, 5'b01111, 64'hFFFF_FFFF, 64'hFFFF_FFFF);
    issue("R8 double signed", 6'b101001, 5'b00000, 64'h10000, 64'h10000);
    issue("R2 upper LO word kept", 6'b101000, 5'b00000, 64'd1, 64'd1);
    issue("R8 double signed sat", 6'b101001, 5'b10000, 64'h7FFF_FFFF, 64'h7FFF_FFFF);
    issue("R8 double unsigned", 6'b101001, 5'b00001, 64'hFFFF_FFFF, 64'h10);
    issue("R8 double unsigned sat", 6'b101001, 5'b10001, 64'h8000_0000, 64'd1);
    issue("R2 acc uses LO low word only", 6'b101000, 5'b00000, 64'd1, 64'd1);
    issue("R5 rd sign extension", 6'b101000, 5'b00100, 64'h8000_0000, 64'd1);
    issue("R12 undefined sa", 6'b101000, 5'b00010, 64'd9, 64'd9);
    issue("R12 undefined funct", 6'b000000, 5'b00000, 64'd9, 64'd9);
    issue("R12 valid low", 6'b101000, 5'b00100, 64'd9, 64'd9, 1'b0);
    issue("R5 strobe drops after one cycle", 6'b101000, 5'b00000, 64'd0, 64'd0, 1'b0);

    @(negedge clk_i);
    valid_i = 1'b0;
    repeat (3) @(negedge clk_i);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule